// File: doc/BRIEF.md
# Relay Activation and Lane-Sum Fabric

This block is the control fabric for a small rectangular grid of compute tiles. The tiles share no data with each other. Permission to compute spreads from root tiles to their neighbours, but only through tiles that were locked when the cycle began, and only along the directional edges each tile enables toward its eight neighbours. The block works out which tiles are active as the least fixed point of this rule. It then lets the permitted tiles place their 4-bit lane values on a shared eight-lane output, where each lane is a saturating sum.

A controller starts a cycle with a valid/ready handshake. The per-tile root, bus-write and lock flags are captured at that moment. The fabric then steps through a read phase, a turnaround gap, a write phase and a readout phase. The read phase has a fixed number of propagation steps equal to the tile count, so the cycle length never depends on the data. At readout the lane results are registered and a one-cycle done pulse is raised. Edge flags and lane contributions are treated as configuration and must stay stable while a cycle runs.

Top module: `relay_fabric`

## Requirements
- R1: After reset, `active_mask`, `drive_mask`, `lanes_out`, `done` and `phase` are all zero, and `start_ready` is high.
- R2: Every tile whose root flag was set at the accepting edge is active.
- R3: A non-root tile is active only if some neighbour that is active and was locked at the accepting edge has an edge pointing to it. An unlocked active tile passes no activation on.
- R4: Edge bit d of tile t (bit index t*8+d, tile index row*COLS+col, row 0 at the top) points to this neighbour: d=0 row-1; d=1 col+1; d=2 row+1; d=3 col-1; d=4 row-1,col+1; d=5 row+1,col+1; d=6 row+1,col-1; d=7 row-1,col-1.
- R5: An edge that points beyond the grid boundary has no effect, and rows do not wrap into one another.
- R6: The active set is the least fixed point. A loop of locked tiles that no root reaches stays inactive.
- R7: Root, lock and bus-write flags are sampled only at the accepting edge. Changes made while a cycle runs do not alter its result.
- R8: A tile drives the lanes exactly when it is active, its bus-write flag is set, and either it is locked or an active locked neighbour has an edge to it. `drive_mask` shows this set after done.
- R9: Output lane l (bits l*4+3..l*4) equals min(15, sum of lane l contributions of the driving tiles). The contribution of tile t on lane l sits at bits (t*8+l)*4+3..(t*8+l)*4.
- R10: `done` rises exactly tiles+3 clock edges after the accepting edge and lasts one cycle. `start_valid` is ignored while a cycle runs.
- R11: `phase` runs IDLE(0), READ(1), TURNAROUND(2), WRITE(3), READOUT(4) and back to IDLE, with exactly one cycle each in TURNAROUND, WRITE and READOUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Controller requests a cycle; ingress values are present |
| start_ready | output | 1 | Fabric idle and able to accept a cycle |
| root_flags | input | ROWS*COLS | Per-tile root flag |
| wr_flags | input | ROWS*COLS | Per-tile bus-write flag |
| lock_flags | input | ROWS*COLS | Per-tile lock state, captured as the snapshot |
| edge_flags | input | ROWS*COLS*8 | Per-tile direction edge flags |
| contrib | input | ROWS*COLS*8*4 | Per-tile, per-lane 4-bit contribution |
| phase | output | 3 | Current phase code |
| active_mask | output | ROWS*COLS | Active tiles of the current or last cycle |
| drive_mask | output | ROWS*COLS | Tiles that drove the lanes in the last write phase |
| lanes_out | output | 32 | Registered saturated lane results |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The bench builds the fabric at its defaults: a 4x4 grid, eight lanes and 4-bit levels. At this size one grid holds corner, edge and interior tiles, so all eight directions can fan out from an interior tile while boundary tiles try edges that leave the grid. Sixteen tiles driving the value 15 give a lane sum far above the clamp. The sixteen-step read phase leaves room to change the lock inputs and to pulse the start request while a cycle runs.

// File: rtl/relay_pkg.sv
package relay_pkg;

  localparam int NDIR = 8;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_READ    = 3'd1,
    PH_TURN    = 3'd2,
    PH_WRITE   = 3'd3,
    PH_READOUT = 3'd4
  } phase_t;

  // Row step of direction d: N, E, S, W, NE, SE, SW, NW
  function automatic int dir_row(input int d);
    case (d)
      0, 4, 7: return -1;
      2, 5, 6: return 1;
      default: return 0;
    endcase
  endfunction

  // Column step of direction d
  function automatic int dir_col(input int d);
    case (d)
      1, 4, 5: return 1;
      3, 6, 7: return -1;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/relay_step.sv
// One propagation step: next = root | (locked active in-neighbours with edge).
module relay_step #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int NT = ROWS * COLS,
  localparam int ND = relay_pkg::NDIR
) (
  input  logic [NT-1:0]    act,
  input  logic [NT-1:0]    lock,
  input  logic [NT-1:0]    root,
  input  logic [NT*ND-1:0] edges,
  output logic [NT-1:0]    anc,
  output logic [NT-1:0]    next_act
);
  import relay_pkg::*;

  logic [ND-1:0] hit [NT];

  for (genvar t = 0; t < NT; t++) begin : g_tile
    localparam int TR = t / COLS;
    localparam int TC = t % COLS;
    for (genvar d = 0; d < ND; d++) begin : g_dir
      // source tile sits one step opposite to direction d
      localparam int SR = TR - dir_row(d);
      localparam int SC = TC - dir_col(d);
      if (SR >= 0 && SR < ROWS && SC >= 0 && SC < COLS) begin : g_in
        localparam int SRC = SR * COLS + SC;
        assign hit[t][d] = act[SRC] & lock[SRC] & edges[SRC*ND + d];
      end else begin : g_off
        assign hit[t][d] = 1'b0;
      end
    end
    assign anc[t]      = |hit[t];
    assign next_act[t] = root[t] | anc[t];
  end

endmodule

// File: rtl/lane_sum.sv
// Wide per-lane sum of contributions from driving tiles.
module lane_sum #(
  parameter int NT = 16,
  parameter int LANES = 8,
  parameter int LW = 4,
  localparam int MAXV = (1 << LW) - 1,
  localparam int SW = $clog2(NT * MAXV + 1)
) (
  input  logic [NT-1:0]          drive,
  input  logic [NT*LANES*LW-1:0] contrib,
  output logic [LANES*SW-1:0]    sums
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int t = 0; t < NT; t++) begin
        if (drive[t]) acc = acc + SW'(contrib[(t*LANES + l)*LW +: LW]);
      end
    end
    assign sums[l*SW +: SW] = acc;
  end

endmodule

// File: rtl/cycle_seq.sv
// Fixed-length phase sequencer.
module cycle_seq #(
  parameter int NT = 16,
  localparam int CW = $clog2(NT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_valid,
  output logic               start_ready,
  output logic               accept,
  output relay_pkg::phase_t  phase
);
  import relay_pkg::*;

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;

  assign phase       = phase_q;
  assign start_ready = (phase_q == PH_IDLE);
  assign accept      = start_valid & start_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_READ;
            cnt_q   <= '0;
          end
        end
        PH_READ: begin
          if (cnt_q == CW'(NT - 1)) phase_q <= PH_TURN;
          else cnt_q <= cnt_q + 1'b1;
        end
        PH_TURN:  phase_q <= PH_WRITE;
        PH_WRITE: phase_q <= PH_READOUT;
        default:  phase_q <= PH_IDLE;
      endcase
    end
  end

  // R11: turnaround is followed by write, write by readout, readout by idle
  a_r11_turn_to_write: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_TURN |=> phase_q == PH_WRITE);
  a_r11_write_to_readout: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_WRITE |=> phase_q == PH_READOUT);
  a_r11_readout_to_idle: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_READOUT |=> phase_q == PH_IDLE);
  // R10: a new read phase is only entered from idle
  a_r10_read_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(phase_q == PH_READ) |-> $past(phase_q) == PH_IDLE);

endmodule

// File: rtl/relay_fabric.sv
module relay_fabric #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int LANES = 8,
  parameter int LW = 4,
  localparam int NT = ROWS * COLS,
  localparam int ND = relay_pkg::NDIR,
  localparam int MAXV = (1 << LW) - 1,
  localparam int SW = $clog2(NT * MAXV + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_valid,
  output logic                   start_ready,
  input  logic [NT-1:0]          root_flags,
  input  logic [NT-1:0]          wr_flags,
  input  logic [NT-1:0]          lock_flags,
  input  logic [NT*ND-1:0]       edge_flags,
  input  logic [NT*LANES*LW-1:0] contrib,
  output logic [2:0]             phase,
  output logic [NT-1:0]          active_mask,
  output logic [NT-1:0]          drive_mask,
  output logic [LANES*LW-1:0]    lanes_out,
  output logic                   done
);
  import relay_pkg::*;

  phase_t ph;
  logic   accept;

  logic [NT-1:0]       root_q, lock_q, wr_q, act_q, drive_q;
  logic [NT-1:0]       anc, next_act, drive_c;
  logic [LANES*SW-1:0] sums_c, sums_q;
  logic [LANES*LW-1:0] clamp_c, lanes_q;
  logic                done_q;

  cycle_seq #(.NT(NT)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start_valid (start_valid),
    .start_ready (start_ready),
    .accept      (accept),
    .phase       (ph)
  );

  relay_step #(.ROWS(ROWS), .COLS(COLS)) u_step (
    .act      (act_q),
    .lock     (lock_q),
    .root     (root_q),
    .edges    (edge_flags),
    .anc      (anc),
    .next_act (next_act)
  );

  assign drive_c = act_q & wr_q & (lock_q | anc);

  lane_sum #(.NT(NT), .LANES(LANES), .LW(LW)) u_sum (
    .drive   (drive_q),
    .contrib (contrib),
    .sums    (sums_c)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_clamp
    logic [SW-1:0] s;
    assign s = sums_q[l*SW +: SW];
    assign clamp_c[l*LW +: LW] = (s > SW'(MAXV)) ? LW'(MAXV) : s[LW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      root_q  <= '0;
      lock_q  <= '0;
      wr_q    <= '0;
      act_q   <= '0;
      drive_q <= '0;
      sums_q  <= '0;
      lanes_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (accept) begin
        root_q <= root_flags;
        lock_q <= lock_flags;
        wr_q   <= wr_flags;
        act_q  <= root_flags;
      end else if (ph == PH_READ) begin
        act_q <= next_act;
      end
      if (ph == PH_TURN)  drive_q <= drive_c;
      if (ph == PH_WRITE) sums_q  <= sums_c;
      if (ph == PH_READOUT) lanes_q <= clamp_c;
      done_q <= (ph == PH_READOUT);
    end
  end

  assign phase       = ph;
  assign active_mask = act_q;
  assign drive_mask  = drive_q;
  assign lanes_out   = lanes_q;
  assign done        = done_q;

  // R2: captured roots stay active for the whole cycle
  a_r2_roots_active: assert property (@(posedge clk) disable iff (rst)
    ph != PH_IDLE |-> (act_q & root_q) == root_q);
  // R6: the active set only grows during propagation
  a_r6_active_grows: assert property (@(posedge clk) disable iff (rst)
    ph == PH_READ |=> (act_q & $past(act_q)) == $past(act_q));
  // R8: driving tiles are active and write-enabled
  a_r8_drive_subset: assert property (@(posedge clk) disable iff (rst)
    ph == PH_WRITE |-> (drive_q & ~(act_q & wr_q)) == '0);
  // R10: done is a single-cycle pulse following readout
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  a_r10_done_after_readout: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(ph) == PH_READOUT);

endmodule

// File: tb/relay_fabric_test.sv
module relay_fabric_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 4;
  localparam int COLS = 4;
  localparam int LANES = 8;
  localparam int LW = 4;
  localparam int NT = ROWS * COLS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_valid = 1'b0;
  logic start_ready;
  logic [NT-1:0] root_flags = '0, wr_flags = '0, lock_flags = '0;
  logic [NT*8-1:0] edge_flags = '0;
  logic [NT*LANES*LW-1:0] contrib = '0;
  logic [2:0] phase;
  logic [NT-1:0] active_mask, drive_mask;
  logic [LANES*LW-1:0] lanes_out;
  logic done;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  relay_fabric #(.ROWS(ROWS), .COLS(COLS), .LANES(LANES), .LW(LW)) uut (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .root_flags(root_flags), .wr_flags(wr_flags), .lock_flags(lock_flags),
    .edge_flags(edge_flags), .contrib(contrib), .phase(phase),
    .active_mask(active_mask), .drive_mask(drive_mask),
    .lanes_out(lanes_out), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // neighbour offsets, independent listing: N E S W NE SE SW NW
  function automatic int drow(input int d);
    int t[8] = '{-1, 0, 1, 0, -1, 1, 1, -1};
    return t[d];
  endfunction
  function automatic int dcol(input int d);
    int t[8] = '{0, 1, 0, -1, 1, 1, -1, -1};
    return t[d];
  endfunction

  // tiles fed by locked active sources
  function automatic logic [NT-1:0] fed(input logic [NT-1:0] act, input logic [NT-1:0] lk);
    logic [NT-1:0] f = '0;
    for (int p = 0; p < NT; p++) begin
      if (act[p] && lk[p]) begin
        for (int d = 0; d < 8; d++) begin
          int r = p / COLS + drow(d);
          int c = p % COLS + dcol(d);
          if (edge_flags[p*8+d] && r >= 0 && r < ROWS && c >= 0 && c < COLS)
            f[r*COLS+c] = 1'b1;
        end
      end
    end
    return f;
  endfunction

  function automatic logic [NT-1:0] model_active(input logic [NT-1:0] rt, input logic [NT-1:0] lk);
    logic [NT-1:0] a = rt;
    for (int i = 0; i < NT; i++) a = rt | fed(a, lk);
    return a;
  endfunction

  task automatic clear_cfg();
    root_flags = '0; wr_flags = '0; lock_flags = '0; edge_flags = '0; contrib = '0;
  endtask

  task automatic set_edge(input int t, input int d);
    edge_flags[t*8+d] = 1'b1;
  endtask

  task automatic set_val(input int t, input int l, input int v);
    contrib[(t*LANES+l)*LW +: LW] = LW'(v);
  endtask

  // Runs one fabric cycle and checks activity, drive set, lanes and latency.
  task automatic run(input string req, input bit flip_lock, input bit poke_start);
    logic [NT-1:0] rt = root_flags, lk = lock_flags, bw = wr_flags;
    logic [NT-1:0] ea, ed;
    logic [LANES*LW-1:0] el;
    int e = 0;
    ea = model_active(rt, lk);
    ed = ea & bw & (lk | fed(ea, lk));
    for (int l = 0; l < LANES; l++) begin
      int s = 0;
      for (int t = 0; t < NT; t++)
        if (ed[t]) s += int'(contrib[(t*LANES+l)*LW +: LW]);
      el[l*LW +: LW] = LW'((s > 15) ? 15 : s);
    end
    @(negedge clk);
    start_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    if (flip_lock) begin
      lock_flags = ~lock_flags; root_flags = ~root_flags; wr_flags = ~wr_flags;
    end
    while (!done && e < NT + 20) begin
      if (poke_start && e == 3) start_valid = 1'b1;
      if (poke_start && e == 6) start_valid = 1'b0;
      @(posedge clk);
      @(negedge clk);
      e++;
    end
    check(e == NT + 3, "R10", {req, " latency"}, e, NT + 3);
    check(active_mask == ea, req, "active mask", active_mask, ea);
    check(drive_mask == ed, "R8", {req, " drive mask"}, drive_mask, ed);
    check(lanes_out == el, "R9", {req, " lanes"}, lanes_out, el);
    if (flip_lock) begin
      lock_flags = lk; root_flags = rt; wr_flags = bw;
    end
  endtask

  task automatic t_reset();
    check(active_mask == 0 && drive_mask == 0, "R1", "masks after reset", {active_mask, drive_mask}, 0);
    check(lanes_out == 0, "R1", "lanes after reset", lanes_out, 0);
    check(done == 0 && phase == 0, "R1", "done/phase after reset", {done, phase}, 0);
    check(start_ready == 1, "R1", "ready after reset", start_ready, 1);
  endtask

  task automatic t_root_only();  // R2
    clear_cfg();
    root_flags[6] = 1; lock_flags[6] = 1; wr_flags[6] = 1;
    root_flags[9] = 1; wr_flags[9] = 1;  // unlocked root with no feed: no drive
    for (int l = 0; l < LANES; l++) begin set_val(6, l, l + 1); set_val(9, l, 3); end
    run("R2", 0, 0);
  endtask

  task automatic t_chain();  // R3
    clear_cfg();
    root_flags[0] = 1; lock_flags[0] = 1; lock_flags[1] = 1;
    set_edge(0, 1); set_edge(1, 1); set_edge(2, 1);
    wr_flags = 16'h000F;
    for (int t = 0; t < 4; t++) set_val(t, 2, 2 + t);
    run("R3", 0, 0);
  endtask

  task automatic t_eight_dirs();  // R4
    clear_cfg();
    root_flags[5] = 1; lock_flags[5] = 1;
    for (int d = 0; d < 8; d++) set_edge(5, d);
    wr_flags = '1;
    for (int t = 0; t < NT; t++) set_val(t, 0, 1);
    run("R4", 0, 0);
    clear_cfg();  // single direction SW from tile 6 reaches tile 9 only
    root_flags[6] = 1; lock_flags[6] = 1; set_edge(6, 6);
    run("R4", 0, 0);
  endtask

  task automatic t_off_grid();  // R5
    clear_cfg();
    root_flags[3] = 1; lock_flags[3] = 1;
    set_edge(3, 0); set_edge(3, 1); set_edge(3, 4); set_edge(3, 5);
    root_flags[4] = 1; lock_flags[4] = 1;
    set_edge(4, 3); set_edge(4, 6); set_edge(4, 7);
    wr_flags = '1;
    for (int t = 0; t < NT; t++) set_val(t, 7, 4);
    run("R5", 0, 0);
  endtask

  task automatic t_loop();  // R6
    clear_cfg();
    lock_flags[10] = 1; lock_flags[11] = 1;
    set_edge(10, 1); set_edge(11, 3);
    wr_flags = '1; set_val(10, 1, 5); set_val(11, 1, 5);
    run("R6", 0, 0);
    root_flags[10] = 1;
    run("R6", 0, 0);
  endtask

  task automatic t_snapshot();  // R7
    clear_cfg();
    root_flags[0] = 1; lock_flags[0] = 1;
    set_edge(0, 2); set_edge(4, 2);
    wr_flags[0] = 1; wr_flags[4] = 1; wr_flags[8] = 1;
    set_val(0, 4, 6); set_val(4, 4, 7); set_val(8, 4, 8);
    run("R7", 1, 0);
  endtask

  task automatic t_saturate();  // R9
    clear_cfg();
    root_flags = '1; lock_flags = '1; wr_flags = '1;
    for (int t = 0; t < NT; t++) begin
      set_val(t, 0, 15);
      if (t < 3) set_val(t, 1, 4);  // 12, below clamp
      if (t < 4) set_val(t, 2, 4);  // 16, clamps to 15
      if (t == 0) set_val(t, 3, 15);  // exactly 15
    end
    run("R9", 0, 0);
  endtask

  task automatic t_busy_ignore();  // R10, R11
    clear_cfg();
    root_flags[1] = 1; lock_flags[1] = 1; wr_flags[1] = 1; set_val(1, 5, 9);
    run("R10", 0, 1);
    begin
      int extra = 0;
      bit saw_turn = 0;
      for (int i = 0; i < NT + 8; i++) begin
        @(posedge clk); @(negedge clk);
        if (done) extra++;
      end
      check(extra == 0, "R10", "no done from ignored start", extra, 0);
      check(phase == 0 && start_ready, "R11", "idle after cycle", phase, 0);
      // observe phase order in a fresh cycle
      @(negedge clk); start_valid = 1'b1;
      @(posedge clk); @(negedge clk); start_valid = 1'b0;
      check(phase == 1, "R11", "read after accept", phase, 1);
      for (int i = 0; i < NT; i++) begin @(posedge clk); @(negedge clk); end
      saw_turn = (phase == 2);
      check(saw_turn, "R11", "turnaround after read", phase, 2);
      @(posedge clk); @(negedge clk);
      check(phase == 3, "R11", "write after turnaround", phase, 3);
      @(posedge clk); @(negedge clk);
      check(phase == 4, "R11", "readout after write", phase, 4);
      @(posedge clk); @(negedge clk);
      check(phase == 0 && done, "R11", "idle with done", {phase, done}, 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_root_only();
    t_chain();
    t_eight_dirs();
    t_off_grid();
    t_loop();
    t_snapshot();
    t_saturate();
    t_busy_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule